// File: doc/BRIEF.md
# Fixed-Point / Single-Precision Conversion Unit

This unit moves numbers between scaled fixed-point integers and IEEE-754 single-precision values. A 3-bit opcode selects the direction and the integer format. A fraction-bit count gives the position of the binary point. In the integer-to-float direction the result is the source integer times 2 to the power of minus the fraction count. In the float-to-fixed direction the float is scaled by 2 to the power of the fraction count, and the result is the integer part of that product.

The rounding rule is fixed by the direction and does not depend on the rounding-mode input. Integer-to-float always rounds to nearest, with ties going to the even mantissa. Float-to-fixed always truncates toward zero, and out-of-range values saturate.

One operation is accepted on any cycle that has the valid strobe high. Its result and flags are registered and appear on the next cycle.

Top module: `fxcvt_unit`

## Requirements
- R1: Opcode bit 2 low selects integer-to-float. Opcode 0 takes a signed 16-bit source, 1 a signed 32-bit source, 2 an unsigned 16-bit source and 3 an unsigned 32-bit source. A 16-bit source is operand bits 15:0, sign-extended for opcode 0 and zero-extended for opcode 2; operand bits 31:16 are then ignored.
- R2: For opcodes 0 to 3 the result is the single-precision encoding (sign bit 31, biased exponent bits 30:23, mantissa bits 22:0) of source times 2^-fbits, for fbits from 0 to 32. It is rounded to nearest with ties to even, whatever value in_rmode holds.
- R3: For opcodes 0 to 3, a zero source gives 0x00000000 with both flags clear. out_inexact is set exactly when rounding discarded nonzero bits, and out_invalid is never set.
- R4: Opcodes 4, 5, 6 and 7 convert a float to signed 16-bit, signed 32-bit, unsigned 16-bit and unsigned 32-bit fixed point. The value is float times 2^fbits, truncated toward zero whatever in_rmode holds. A 16-bit result is sign-extended (opcode 4) or zero-extended (opcode 6) to 32 bits. out_inexact is set when nonzero fraction bits were dropped.
- R5: A float-to-fixed value outside the destination range gives the destination maximum (positive side) or minimum (negative side) and sets out_invalid. This includes the infinities. For an unsigned destination, a negative value whose magnitude is at least 1 gives 0 and sets out_invalid. A negative value with magnitude below 1 gives 0 and sets out_inexact only.
- R6: A NaN input (exponent field all ones, nonzero mantissa) to opcodes 4 to 7 gives 0 and sets out_invalid.
- R7: out_valid is high in exactly the cycles that follow a cycle with in_valid high. The result and flags then belong to that operation.
- R8: A synchronous active-high reset clears out_valid, out_result and both flags to 0.
- R9: out_inexact and out_invalid are never both set; a saturated or NaN result reports invalid only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_opcode | input | 3 | Operation select (see R1, R4) |
| in_operand | input | 32 | Integer source or float source |
| in_fbits | input | 6 | Fraction-bit count, 0 to 32 |
| in_rmode | input | 2 | Configured rounding mode, has no effect on the result |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 32 | Float or fixed-point result |
| out_inexact | output | 1 | Nonzero bits discarded |
| out_invalid | output | 1 | Saturation or NaN input |

## Verification
Every result, including both flags, is due exactly one clock after the cycle that carries in_valid. The bench applies inputs on a falling edge, computes the expected values from a behavioural model built on real arithmetic, and compares them on the next falling edge. It makes that comparison on every cycle. Idle cycles are checked for out_valid being low, so a result that arrives early, late or twice is reported.

// File: rtl/fxcvt_pkg.sv
package fxcvt_pkg;
  localparam int WORD_W   = 32;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_BIAS  = 127;

  typedef enum logic [2:0] {
    OP_S16_TO_F = 3'd0,
    OP_S32_TO_F = 3'd1,
    OP_U16_TO_F = 3'd2,
    OP_U32_TO_F = 3'd3,
    OP_F_TO_S16 = 3'd4,
    OP_F_TO_S32 = 3'd5,
    OP_F_TO_U16 = 3'd6,
    OP_F_TO_U32 = 3'd7
  } cvt_op_e;
endpackage

// File: rtl/fxcvt_fix2flt.sv
module fxcvt_fix2flt
  import fxcvt_pkg::*;
#(
  parameter int FBITS_W = 6
) (
  input  logic [WORD_W-1:0]  src,
  input  logic               src_signed,
  input  logic [FBITS_W-1:0] fbits,
  output logic [WORD_W-1:0]  flt,
  output logic               inexact
);
  localparam int LEAD_W = $clog2(WORD_W);
  localparam int GRD    = WORD_W - 2 - SP_MAN_W;

  logic                neg;
  logic [WORD_W-1:0]   mag;
  logic [WORD_W-1:0]   norm;
  logic [LEAD_W-1:0]   lead;
  logic [SP_MAN_W-1:0] man_t;
  logic [SP_MAN_W-1:0] man_r;
  logic                grd, stk, up, carry;
  logic [SP_EXP_W-1:0] exp_c;

  always_comb begin
    neg  = src_signed & src[WORD_W-1];
    mag  = neg ? (~src + 1'b1) : src;
    lead = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (mag[i]) lead = LEAD_W'(i);
    end
    norm  = mag << (LEAD_W'(WORD_W - 1) - lead);
    man_t = norm[WORD_W-2 -: SP_MAN_W];
    grd   = norm[GRD];
    stk   = |norm[GRD-1:0];
    up    = grd & (stk | norm[GRD+1]);
    {carry, man_r} = {1'b0, man_t} + (SP_MAN_W + 1)'(up);
    exp_c = SP_EXP_W'(SP_BIAS) + SP_EXP_W'(lead) - SP_EXP_W'(fbits) + SP_EXP_W'(carry);
    if (mag == '0) begin
      flt     = '0;
      inexact = 1'b0;
    end else begin
      flt     = {neg, exp_c, man_r};
      inexact = grd | stk;
    end
  end
endmodule

// File: rtl/fxcvt_flt2fix.sv
module fxcvt_flt2fix
  import fxcvt_pkg::*;
#(
  parameter int FBITS_W = 6
) (
  input  logic [WORD_W-1:0]  flt,
  input  logic [FBITS_W-1:0] fbits,
  input  logic               dst_signed,
  input  logic               dst_wide,
  output logic [WORD_W-1:0]  fix,
  output logic               inexact,
  output logic               invalid
);
  localparam int SIG_W  = SP_MAN_W + 1;
  localparam int MAG_W  = WORD_W + 8;
  localparam int SH_W   = 11;
  localparam int RSH_W  = $clog2(SIG_W + 1);
  localparam int HUGE_S = WORD_W + 2 - SP_MAN_W;

  logic                      sgn;
  logic [SP_EXP_W-1:0]       ex, ex_eff;
  logic [SP_MAN_W-1:0]       mn;
  logic [SIG_W-1:0]          sig;
  logic signed [SH_W-1:0]    sh;
  logic [RSH_W-1:0]          rsh;
  logic [MAG_W-1:0]          mag, pos_max, neg_lim;
  logic [6:0]                nb;
  logic                      lost, huge, is_nan, is_inf;

  always_comb begin
    sgn    = flt[WORD_W-1];
    ex     = flt[WORD_W-2 -: SP_EXP_W];
    mn     = flt[SP_MAN_W-1:0];
    is_nan = (ex == '1) && (mn != '0);
    is_inf = (ex == '1) && (mn == '0);
    sig    = {ex != '0, mn};
    ex_eff = (ex == '0) ? SP_EXP_W'(1) : ex;
    sh     = SH_W'(ex_eff) + SH_W'(fbits) - SH_W'(SP_BIAS + SP_MAN_W);
    rsh    = RSH_W'(-sh);
    huge   = 1'b0;
    lost   = 1'b0;
    mag    = '0;
    if (sh >= SH_W'(HUGE_S)) begin
      huge = 1'b1;
    end else if (sh >= 0) begin
      mag = MAG_W'(sig) << sh[3:0];
    end else if (sh > -SH_W'(SIG_W + 1)) begin
      mag  = MAG_W'(sig >> rsh);
      lost = |(sig & ((SIG_W'(1) << rsh) - 1'b1));
    end else begin
      lost = |sig;
    end

    nb      = dst_wide ? 7'd32 : 7'd16;
    pos_max = (MAG_W'(1) << (nb - 7'(dst_signed))) - 1'b1;
    neg_lim = dst_signed ? (MAG_W'(1) << (nb - 7'd1)) : '0;

    fix     = '0;
    inexact = 1'b0;
    invalid = 1'b0;
    if (is_nan) begin
      invalid = 1'b1;
    end else if (!sgn && (is_inf || huge || mag > pos_max)) begin
      fix     = pos_max[WORD_W-1:0];
      invalid = 1'b1;
    end else if (sgn && (is_inf || huge || mag > neg_lim)) begin
      fix     = -neg_lim[WORD_W-1:0];
      invalid = 1'b1;
    end else begin
      fix     = sgn ? -mag[WORD_W-1:0] : mag[WORD_W-1:0];
      inexact = lost;
    end
  end
endmodule

// File: rtl/fxcvt_unit.sv
module fxcvt_unit
  import fxcvt_pkg::*;
#(
  parameter int FBITS_W   = 6,
  parameter int MAX_FBITS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2:0]         in_opcode,
  input  logic [WORD_W-1:0]  in_operand,
  input  logic [FBITS_W-1:0] in_fbits,
  input  logic [1:0]         in_rmode,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_result,
  output logic               out_inexact,
  output logic               out_invalid
);
  localparam int HALF_W = WORD_W / 2;

  logic              to_fixed, is_unsigned, is_wide;
  logic [WORD_W-1:0] src_ext;
  logic [WORD_W-1:0] f_res, x_res;
  logic              f_inx, x_inx, x_inv;

  assign to_fixed    = in_opcode[2];
  assign is_unsigned = in_opcode[1];
  assign is_wide     = in_opcode[0];

  always_comb begin
    if (is_wide)
      src_ext = in_operand;
    else if (is_unsigned)
      src_ext = {{HALF_W{1'b0}}, in_operand[HALF_W-1:0]};
    else
      src_ext = {{HALF_W{in_operand[HALF_W-1]}}, in_operand[HALF_W-1:0]};
  end

  fxcvt_fix2flt #(.FBITS_W(FBITS_W)) u_fix2flt (
    .src        (src_ext),
    .src_signed (!is_unsigned),
    .fbits      (in_fbits),
    .flt        (f_res),
    .inexact    (f_inx)
  );

  fxcvt_flt2fix #(.FBITS_W(FBITS_W)) u_flt2fix (
    .flt        (in_operand),
    .fbits      (in_fbits),
    .dst_signed (!is_unsigned),
    .dst_wide   (is_wide),
    .fix        (x_res),
    .inexact    (x_inx),
    .invalid    (x_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= to_fixed ? x_res : f_res;
        out_inexact <= to_fixed ? x_inx : f_inx;
        out_invalid <= to_fixed && x_inv;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst) out_valid |-> !(out_inexact && out_invalid)); // R9
  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode[2] && in_operand[30:23] == 8'hFF && in_operand[22:0] != 0)
    |=> (out_result == 0 && out_invalid)); // R6
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_opcode[2] && (in_opcode[0] ? in_operand == 0 : in_operand[15:0] == 0))
    |=> (out_result == 0 && !out_inexact && !out_invalid)); // R3
  AST_U16_EXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OP_F_TO_U16) |=> out_result[31:16] == 16'h0); // R4
  AST_S16_EXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OP_F_TO_S16) |=> out_result[31:16] == {16{out_result[15]}}); // R4
  AST_FBITS_RANGE: assert property (@(posedge clk) disable iff (rst) in_valid |-> in_fbits <= MAX_FBITS); // R2
  AST_RMODE_KNOWN: assert property (@(posedge clk) disable iff (rst) in_valid |-> !$isunknown(in_rmode)); // R2
endmodule

// File: tb/fxcvt_unit_test.sv
`timescale 1ns/1ps
module fxcvt_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_opcode;
  logic [31:0] in_operand;
  logic [5:0]  in_fbits;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact;
  logic        out_invalid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit          p_v;
  logic [31:0] p_res;
  bit          p_inx, p_inv;
  string       p_tag;
  logic [31:0] rng = 32'h1234ABCD;

  always #2.5 clk = ~clk;

  fxcvt_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_operand(in_operand), .in_fbits(in_fbits), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  function automatic real pow2(input int k);
    real p = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
    else        for (int i = 0; i < -k; i++) p = p / 2.0;
    return p;
  endfunction

  function automatic void ref_i2f(input logic [2:0] op, input logic [31:0] x, input int fb,
                                  output logic [31:0] res, output bit inx, output bit inv);
    longint v;
    real r;
    logic [63:0] b;
    logic [22:0] keep;
    logic [28:0] rest;
    int ex;
    bit up;
    logic [23:0] sum;
    case (op)
      3'd0: v = longint'($signed(x[15:0]));
      3'd1: v = longint'($signed(x));
      3'd2: v = longint'({48'h0, x[15:0]});
      default: v = longint'({32'h0, x});
    endcase
    inv = 1'b0;
    if (v == 0) begin
      res = 32'h0; inx = 1'b0;
      return;
    end
    r    = real'(v) / pow2(fb);
    b    = $realtobits(r);
    keep = b[51:29];
    rest = b[28:0];
    ex   = int'(b[62:52]) - 1023 + 127;
    up   = rest[28] && (rest[27:0] != 0 || keep[0]);
    sum  = {1'b0, keep} + 24'(up);
    if (sum[23]) ex = ex + 1;
    res  = {b[63], 8'(ex), sum[22:0]};
    inx  = (rest != 0);
  endfunction

  function automatic void ref_f2i(input logic [2:0] op, input logic [31:0] f, input int fb,
                                  output logic [31:0] res, output bit inx, output bit inv);
    bit  sg = f[31];
    int  e  = int'(f[30:23]);
    int  m  = int'(f[22:0]);
    bit  sd = !op[1];
    int  nb = op[0] ? 32 : 16;
    real hi = sd ? pow2(nb - 1) - 1.0 : pow2(nb) - 1.0;
    real lo = sd ? -pow2(nb - 1) : 0.0;
    real mg, sc, fl;
    inx = 1'b0; inv = 1'b0;
    if (e == 255 && m != 0) begin
      res = 32'h0; inv = 1'b1;
    end else if (e == 255) begin
      inv = 1'b1;
      res = sg ? 32'(longint'(lo)) : 32'(longint'(hi));
    end else begin
      mg = (e == 0) ? real'(m) * pow2(-149) : real'(m + 8388608) * pow2(e - 150);
      sc = mg * pow2(fb);
      fl = $floor(sc);
      if (!sg) begin
        if (fl > hi) begin res = 32'(longint'(hi)); inv = 1'b1; end
        else begin res = 32'(longint'(fl)); inx = (sc != fl); end
      end else begin
        if (-fl < lo) begin res = 32'(longint'(lo)); inv = 1'b1; end
        else begin res = 32'(-longint'(fl)); inx = (sc != fl); end
      end
    end
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One clock: compare the operation issued last cycle, then issue the next one.
  task automatic step(input bit v, input logic [2:0] op, input logic [31:0] x,
                      input int fb, input logic [1:0] rm, input string tag);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== p_v) begin
      n_bad++;
      $display("FAIL %s: out_valid got %b expected %b", p_tag, out_valid, p_v);
    end else if (p_v && (out_result !== p_res || out_inexact !== p_inx || out_invalid !== p_inv)) begin
      n_bad++;
      $display("FAIL %s: result/inexact/invalid got %h/%b/%b expected %h/%b/%b",
               p_tag, out_result, out_inexact, out_invalid, p_res, p_inx, p_inv);
    end
    in_valid   = v;
    in_opcode  = op;
    in_operand = x;
    in_fbits   = 6'(fb);
    in_rmode   = rm;
    p_v   = v;
    p_tag = v ? tag : "R7";
    if (v) begin
      if (op[2]) ref_f2i(op, x, fb, p_res, p_inx, p_inv);
      else       ref_i2f(op, x, fb, p_res, p_inx, p_inv);
    end
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 32'h0, 0, 2'd0, "R7");
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_opcode = 3'd0; in_operand = 32'h0;
    in_fbits = 6'd0; in_rmode = 2'd0; p_v = 1'b0; p_tag = "R8";
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_result !== 32'h0 || out_inexact !== 1'b0 || out_invalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: reset outputs got %b/%h/%b/%b expected 0/00000000/0/0",
               out_valid, out_result, out_inexact, out_invalid);
    end
    rst = 1'b0;
    idle();
    // R1 / R2: source formats, halfword selection, scaling
    step(1, 3'd0, 32'h0000FFFF, 0, 2'd0, "R1 s16 -1");
    step(1, 3'd0, 32'hABCD8000, 0, 2'd1, "R1 s16 upper bits ignored");
    step(1, 3'd2, 32'hFFFF8000, 0, 2'd2, "R1 u16 zero-extend");
    step(1, 3'd1, 32'h80000000, 32, 2'd3, "R2 s32 min frac 32");
    step(1, 3'd3, 32'h00000180, 8, 2'd0, "R2 u32 1.5");
    // R2: ties to even under every rounding mode
    for (int rm = 0; rm < 4; rm++) begin
      step(1, 3'd3, 32'h01000001, 0, 2'(rm), "R2 tie to even down");
      step(1, 3'd3, 32'h01000003, 0, 2'(rm), "R2 tie to even up");
      step(1, 3'd1, 32'hFEFFFFFD, 0, 2'(rm), "R2 negative tie");
    end
    step(1, 3'd3, 32'hFFFFFFFF, 0, 2'd1, "R3 carry into exponent inexact");
    step(1, 3'd1, 32'h00000000, 5, 2'd2, "R3 zero source");
    step(1, 3'd0, 32'h12340000, 0, 2'd0, "R3 zero low half");
    idle();
    // R4: truncation and extension
    for (int rm = 0; rm < 4; rm++) begin
      step(1, 3'd4, 32'h3FC00000, 0, 2'(rm), "R4 1.5 -> 1");
      step(1, 3'd4, 32'hBFC00000, 0, 2'(rm), "R4 -1.5 -> -1");
    end
    step(1, 3'd5, 32'h3FC00000, 4, 2'd0, "R4 scaled exact");
    step(1, 3'd6, 32'h477FFF00, 0, 2'd0, "R4 u16 65535");
    step(1, 3'd7, 32'h4F7FFFFF, 0, 2'd0, "R4 u32 large");
    step(1, 3'd5, 32'hCF000000, 0, 2'd0, "R4 s32 min exact");
    step(1, 3'd5, 32'h00000001, 32, 2'd0, "R4 denormal");
    // R5: saturation
    step(1, 3'd4, 32'h471C4000, 0, 2'd0, "R5 s16 pos sat");
    step(1, 3'd4, 32'hC71C4000, 0, 2'd0, "R5 s16 neg sat");
    step(1, 3'd6, 32'hBF800000, 0, 2'd0, "R5 u16 negative");
    step(1, 3'd7, 32'hBF000000, 0, 2'd0, "R5 u32 small negative");
    step(1, 3'd7, 32'h4F800000, 0, 2'd0, "R5 u32 2^32 sat");
    step(1, 3'd5, 32'h7F800000, 0, 2'd0, "R5 +inf");
    step(1, 3'd5, 32'hFF800000, 0, 2'd0, "R5 -inf");
    step(1, 3'd5, 32'h3F800000, 32, 2'd0, "R5 1.0 frac 32 sat");
    // R6: NaN
    step(1, 3'd4, 32'h7FC00000, 0, 2'd0, "R6 quiet NaN");
    step(1, 3'd7, 32'hFF800001, 3, 2'd0, "R6 signaling NaN");
    idle(); idle();
    // R9 / R2 / R4: sweep
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); b = rng;
      if (b[7]) begin
        step(1, b[2:0], a, int'(b[15:8]) % 33, b[17:16], b[2] ? "R9 sweep f2x" : "R9 sweep x2f");
      end else begin
        // floats near the integer range of the destination
        step(1, {1'b1, b[1:0]}, {a[31], 8'(118 + int'(b[12:8])), a[22:0]},
             int'(b[20:16]) % 33, b[22:21], "R4 sweep near range");
      end
      if (b[30:28] == 3'd0) idle();
    end
    idle(); idle();
    finish_run();
  end
endmodule